// File: doc/BRIEF.md
# Token Rate Limiter

This block enforces a maximum send rate on a single output port. It keeps a signed token balance that grows by 16 tokens on every clock. A packet is charged two amounts. The first is a fixed per-packet cost. The second is a per-word cost multiplied by the number of 8-byte words the packet carries. Software sets three values: the per-packet cost, the per-word cost and the burst limit.

The per-packet cost and the burst limit are given in steps of 1/256. Inside the block they are multiplied by 256 before they are compared with the raw balance.

At run time the port's transmit logic raises a request together with the packet's word count. In the same cycle the block answers with either allow or stall. With a word cost of zero, only packets are counted, which gives a packet-rate limit. With a non-zero word cost and a packet cost that covers the per-packet line overhead, the limit follows bits. Converting a target rate into the three settings is left to software.

Top module: `token_rate_limiter`

## Requirements
- R1: Reset loads the balance with the full burst allowance (burst limit × 256). A burst limit of 4 with a packet cost of 1 therefore lets five back-to-back packets through before the sixth stalls. While no request is raised, both allow and stall are low.
- R2: While a request is raised, exactly one of allow and stall is high in the same cycle. Allow is given only when the balance is zero or positive.
- R3: Each allowed packet subtracts packet cost × 256 + word cost × word count from the balance at the next clock edge.
- R4: Every clock adds 16 tokens to the balance, whether or not a request is raised.
- R5: The balance never rises above burst limit × 256. Idle time beyond that point earns no extra credit.
- R6: With a word cost of zero, the word count has no effect on the charge.
- R7: The balance may go negative after a charge. A held request then stalls for exactly ceil(−balance / 16) cycles and is allowed in the cycle the balance reaches zero or above.
- R8: A burst limit of zero disables limiting: every request is allowed at once. While the limit is zero the balance is held at zero, so re-enabling starts from an empty balance.
- R9: An idle cycle charges nothing. The balance only refills during the idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pkt_cost | input | PKT_W | Per-packet cost, in units of 1/256 of the scaled balance |
| cfg_word_cost | input | WORD_W | Cost per 8-byte word, in raw tokens |
| cfg_burst | input | LIM_W | Burst limit, in units of 1/256; zero disables limiting |
| req_valid | input | 1 | Start-of-packet request |
| req_words | input | CNT_W | Number of 8-byte words in the requesting packet |
| allow | output | 1 | Request may start this cycle and is charged |
| stall | output | 1 | Request must wait |

## Verification
The balance can only be seen through the length of stalls. Each scenario therefore drives a held request and counts the stalled cycles against a value worked out by hand from the costs. A wrong refill step, scale shift or charge term changes that count on the very next blocked packet. A missing saturation or an incorrect reset load shows up as extra packets allowed in a burst after idle time. A wrong verdict shows in the same cycle the request is raised.

// File: rtl/rl_pkg.sv
// Shared constants for the token rate limiter.
// Assumes: the refill step and the 1/256 cost scale are fixed by the
// software that computes the settings.
package rl_pkg;
    localparam int REFILL_PER_CLK = 16;
    localparam int COST_SHIFT     = 8;
endpackage

// File: rtl/rl_charge_calc.sv
// Computes the token charge of one packet: scaled packet cost plus
// word cost times word count.
// Assumes: CHG_W is wide enough to hold the sum without overflow.
module rl_charge_calc
    import rl_pkg::*;
#(
    parameter int PKT_W  = 16,
    parameter int WORD_W = 16,
    parameter int CNT_W  = 12,
    parameter int CHG_W  = 29
) (
    input  logic [PKT_W-1:0]  pkt_cost,
    input  logic [WORD_W-1:0] word_cost,
    input  logic [CNT_W-1:0]  words,
    output logic [CHG_W-1:0]  charge
);
    logic [CHG_W-1:0] pkt_part;
    logic [CHG_W-1:0] word_part;

    // Scale the packet cost, multiply out the word cost and add them.
    always_comb begin
        pkt_part  = CHG_W'(pkt_cost) << COST_SHIFT;
        word_part = CHG_W'(word_cost) * CHG_W'(words);
        charge    = pkt_part + word_part;
    end
endmodule

// File: rtl/rl_token_acct.sv
// Signed token balance: refills every clock, is charged on an allowed
// packet, saturates at the scaled burst limit, and is held at zero
// when the limit is zero.
// Assumes: ACC_W exceeds both CAP_W and CHG_W by at least one bit, so
// the zero-extended operands stay positive.
module rl_token_acct
    import rl_pkg::*;
#(
    parameter int CAP_W = 24,
    parameter int CHG_W = 29,
    parameter int ACC_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CAP_W-1:0] cap,
    input  logic [CHG_W-1:0] charge,
    input  logic             charge_en,
    output logic             acct_neg,
    output logic             limit_off
);
    logic signed [ACC_W-1:0] acct_q;
    logic signed [ACC_W-1:0] cap_s;
    logic signed [ACC_W-1:0] chg_full_s;
    logic signed [ACC_W-1:0] chg_s;
    logic signed [ACC_W-1:0] refill_s;
    logic signed [ACC_W-1:0] sum_s;
    logic signed [ACC_W-1:0] next_s;

    // Widen the operands and form the saturated next balance.
    always_comb begin
        cap_s      = $signed({{(ACC_W-CAP_W){1'b0}}, cap});
        chg_full_s = $signed({{(ACC_W-CHG_W){1'b0}}, charge});
        chg_s      = charge_en ? chg_full_s : '0;
        refill_s   = $signed(ACC_W'(REFILL_PER_CLK));
        sum_s      = acct_q + refill_s - chg_s;
        limit_off  = (cap == '0);
        next_s     = limit_off ? '0 : ((sum_s > cap_s) ? cap_s : sum_s);
        acct_neg   = acct_q[ACC_W-1];
    end

    // Balance register: reset loads the full burst allowance.
    always_ff @(posedge clk) begin
        if (!rst_n) acct_q <= cap_s;
        else        acct_q <= next_s;
    end

    assert_charge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(charge_en) && !$past(limit_off) &&
         ($past(acct_q) + $past(refill_s) - $past(chg_full_s) <= $past(cap_s)))
        |-> (acct_q == $past(acct_q) + $past(refill_s) - $past(chg_full_s)));

    assert_refill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(charge_en) && !$past(limit_off) &&
         ($past(acct_q) + $past(refill_s) <= $past(cap_s)))
        |-> (acct_q == $past(acct_q) + $past(refill_s)));

    assert_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cap_s) |-> (acct_q <= cap_s));

    assert_zero_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(limit_off) |-> (acct_q == '0));
endmodule

// File: rtl/token_rate_limiter.sv
// Per-port token rate limiter: answers a start-of-packet request with
// allow or stall in the same cycle and charges allowed packets.
// Assumes: the requester holds req_valid and req_words stable until
// allow is seen; a packet is taken on the edge where allow is high.
module token_rate_limiter
    import rl_pkg::*;
#(
    parameter int PKT_W  = 16,
    parameter int WORD_W = 16,
    parameter int LIM_W  = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PKT_W-1:0]  cfg_pkt_cost,
    input  logic [WORD_W-1:0] cfg_word_cost,
    input  logic [LIM_W-1:0]  cfg_burst,
    input  logic              req_valid,
    input  logic [CNT_W-1:0]  req_words,
    output logic              allow,
    output logic              stall
);
    localparam int PKT_SPAN  = PKT_W + COST_SHIFT;
    localparam int WORD_SPAN = WORD_W + CNT_W;
    localparam int CHG_W     = ((PKT_SPAN > WORD_SPAN) ? PKT_SPAN : WORD_SPAN) + 1;
    localparam int CAP_W     = LIM_W + COST_SHIFT;
    localparam int ACC_W     = ((CHG_W > CAP_W) ? CHG_W : CAP_W) + 2;

    logic [CHG_W-1:0] charge;
    logic [CAP_W-1:0] cap;
    logic             acct_neg;
    logic             limit_off;

    rl_charge_calc #(
        .PKT_W (PKT_W),
        .WORD_W(WORD_W),
        .CNT_W (CNT_W),
        .CHG_W (CHG_W)
    ) u_charge (
        .pkt_cost (cfg_pkt_cost),
        .word_cost(cfg_word_cost),
        .words    (req_words),
        .charge   (charge)
    );

    rl_token_acct #(
        .CAP_W(CAP_W),
        .CHG_W(CHG_W),
        .ACC_W(ACC_W)
    ) u_acct (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .charge   (charge),
        .charge_en(allow),
        .acct_neg (acct_neg),
        .limit_off(limit_off)
    );

    // Scale the burst limit and decide the verdict for this cycle.
    always_comb begin
        cap   = {cfg_burst, {COST_SHIFT{1'b0}}};
        allow = req_valid & (limit_off | ~acct_neg);
        stall = req_valid & ~allow;
    end

    assert_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones({allow, stall}) == 1));

    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!allow && !stall));
endmodule

// File: tb/sim_token_rate_limiter.sv
// Directed bench for the token rate limiter: stall lengths are
// predicted by hand from the costs and compared with the design.
module sim_token_rate_limiter;
    localparam int PKT_W  = 16;
    localparam int WORD_W = 16;
    localparam int LIM_W  = 16;
    localparam int CNT_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PKT_W-1:0]  cfg_pkt_cost = '0;
    logic [WORD_W-1:0] cfg_word_cost = '0;
    logic [LIM_W-1:0]  cfg_burst = '0;
    logic              req_valid = 1'b0;
    logic [CNT_W-1:0]  req_words = '0;
    logic              allow;
    logic              stall;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    token_rate_limiter #(
        .PKT_W(PKT_W), .WORD_W(WORD_W), .LIM_W(LIM_W), .CNT_W(CNT_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_pkt_cost(cfg_pkt_cost), .cfg_word_cost(cfg_word_cost),
        .cfg_burst(cfg_burst), .req_valid(req_valid), .req_words(req_words),
        .allow(allow), .stall(stall)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Apply settings under reset; check the idle outputs afterwards (R1).
    task automatic do_reset(input int burst, input int pcost, input int wcost);
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        cfg_burst = LIM_W'(burst);
        cfg_pkt_cost = PKT_W'(pcost);
        cfg_word_cost = WORD_W'(wcost);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!allow && !stall, "R1 idle outputs", int'({allow, stall}), 0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Hold a request, count stalled cycles and compare (R2, R7).
    task automatic send(input int words, input int exp_st, input string req);
        int st = 0;
        bit bad = 1'b0;
        req_valid = 1'b1;
        req_words = CNT_W'(words);
        #1;
        while (!allow && st < 4000) begin
            if (stall !== 1'b1) bad = 1'b1;
            st++;
            @(negedge clk);
            #1;
        end
        check(st == exp_st, req, st, exp_st);
        check(!bad && stall === 1'b0, "R2 stall during wait", int'(bad), 0);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_burst();
        do_reset(4, 1, 0);
        for (int i = 0; i < 5; i++) send(0, 0, "R1 burst from reset");
        send(0, 11, "R7 stall after burst");
    endtask

    task automatic t_words();
        do_reset(1, 2, 8);
        send(10, 0, "R3 first bit-mode packet");
        send(10, 20, "R3 packet plus word charge");
        send(0, 36, "R3 second full charge");
        send(3, 31, "R3 packet-only charge");
        send(0, 33, "R3 odd remainder rounds up");
    endtask

    task automatic t_pktmode();
        do_reset(1, 1, 0);
        send(4095, 0, "R6 large word count");
        send(0, 0, "R6 second packet");
        send(4095, 14, "R6 words ignored");
        send(7, 15, "R6 words ignored again");
    endtask

    task automatic t_refill();
        do_reset(1, 1, 0);
        send(0, 0, "R4 first");
        send(0, 0, "R4 second");
        idle(10);
        send(0, 4, "R9 idle refill only");
        idle(40);
        send(0, 0, "R5 after long idle");
        send(0, 0, "R5 second after idle");
        send(0, 14, "R5 credit capped");
    endtask

    task automatic t_off();
        do_reset(0, 100, 100);
        for (int i = 0; i < 5; i++) send(4095, 0, "R8 limit disabled");
        cfg_burst = LIM_W'(1);
        cfg_pkt_cost = PKT_W'(1);
        cfg_word_cost = '0;
        send(0, 0, "R8 re-enable first");
        send(0, 15, "R8 balance started empty");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        t_burst();
        t_words();
        t_pktmode();
        t_refill();
        t_off();
        finish_run();
    end
endmodule